// File: doc/BRIEF.md
# Bridge Link Status Synchronizer

This block sits in a bridge or downstream port and brings the port's link status word in line with the device below it. From the port's configured maximum lane count and maximum speed code it derives the link capability bits: bandwidth notification, link-active reporting, the target link speed and the supported-speeds vector. It then rebuilds the negotiated width and speed fields of the port's own status word from the status word that the downstream device reports.

The reported values are cleaned up before use. A width or speed above the port's maximum is clamped to that maximum. A zero, which is not a valid value, is replaced by the minimum (x1 or the 2.5 GT/s code). When no device is attached, or the device has no express capability, the port's maximum values are used instead. All status bits outside the two fields keep their value from the port's own word. The only exception is link-active, which is forced on for ports faster than 2.5 GT/s.

The core is combinational. With `REG_OUT` set (the default), every output is captured in a register on a clock edge where the `sync_i` strobe is high, and holds between strobes. Software or a hot-plug sequencer pulses the strobe whenever the device or the configuration changes.

Top module: `lnk_status_sync`

## Requirements
- R1: When `dev_present_i` is 0 or `dev_has_cap_i` is 0, the output width field takes the configured maximum width and the speed field takes the configured maximum speed, whatever the downstream word holds.
- R2: A reported width (downstream bits [9:4]) greater than the maximum width is replaced by the maximum. A width from 1 up to the maximum passes through unchanged.
- R3: A reported width of 0 becomes 1 (x1).
- R4: A reported speed code (downstream bits [3:0]; 1=2.5, 2=5, 3=8, 4=16 GT/s) greater than the maximum speed is replaced by the maximum. A code of 0 becomes 1. A code from 1 up to the maximum passes through.
- R5: Output bits [15:10] equal the port's own status bits [15:10]. The one exception is bit 13 (link active), which is set when the maximum speed is above 1. The port's own bits [9:0] are overwritten.
- R6: `cap_bw_notify_o` is 1 exactly when the maximum width is above 1 or the maximum speed code is above 1.
- R7: When the maximum speed code is above 1, `cap_active_rpt_o` is 1, status bit 13 is 1 and `tgt_speed_o` equals the maximum speed. Otherwise `cap_active_rpt_o` is 0 and `tgt_speed_o` is 0.
- R8: `speed_vec_o` bit i stands for speed code i+1. It is 0000 when the maximum code is 2 or below, 0111 when the maximum is 3, and 1111 when the maximum is 4.
- R9: With the registered stage, reset clears every output to 0. Outputs change only on a clock edge with `sync_i` high, and they take that cycle's computed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Capture strobe for the output register |
| cfg_max_width_i | input | 6 | Port maximum lane count |
| cfg_max_speed_i | input | 4 | Port maximum speed code |
| dev_present_i | input | 1 | A downstream device is attached |
| dev_has_cap_i | input | 1 | The downstream device has an express capability |
| dev_lnk_sta_i | input | 16 | Link status word reported by the downstream device |
| own_lnk_sta_i | input | 16 | Port's current link status word |
| lnk_sta_o | output | 16 | Updated port link status word |
| cap_bw_notify_o | output | 1 | Bandwidth notification capability |
| cap_active_rpt_o | output | 1 | Link-active reporting capability |
| tgt_speed_o | output | 4 | Target link speed default |
| speed_vec_o | output | 4 | Supported speeds vector |

## Verification
The clean-up path is driven with a reported width and speed above the maximums, with zeros, and with in-range values. These three cases separate a clamp, a zero fix-up and a plain pass-through, which a single pattern would blur together. Absent and capability-less devices are given a deliberately odd downstream word, so that any leak of that word into the output shows. The port's own word is driven with all ones and with patterns in its upper bits at low and high maximum speeds, to tell a preserved bit from a forced one. The capability bits are swept across maximum speeds 1 to 4 and widths 1 and above, which exposes each threshold.

// File: rtl/lnk_sync_pkg.sv
package lnk_sync_pkg;
  localparam int SPD_W   = 4;
  localparam int WID_W   = 6;
  localparam int STA_W   = 16;
  localparam int SPD_LSB = 0;
  localparam int WID_LSB = 4;
  localparam int ACT_BIT = 13;
  localparam int NVEC    = 4;

  localparam logic [SPD_W-1:0] SPD_2G5 = 4'd1;
  localparam logic [SPD_W-1:0] SPD_5G  = 4'd2;
  localparam logic [SPD_W-1:0] SPD_8G  = 4'd3;
  localparam logic [WID_W-1:0] WID_X1  = 6'd1;

  typedef struct packed {
    logic             bw_notify;
    logic             active_rpt;
    logic [SPD_W-1:0] tgt_speed;
    logic [NVEC-1:0]  speed_vec;
  } lnk_cap_t;
endpackage

// File: rtl/lnk_field_fix.sv
module lnk_field_fix #(
  parameter int W = 4,
  parameter logic [W-1:0] MIN_CODE = 1
) (
  input  logic         use_limit,
  input  logic [W-1:0] reported,
  input  logic [W-1:0] limit,
  output logic [W-1:0] fixed
);
  always_comb begin
    if (use_limit)              fixed = limit;
    else if (reported > limit)  fixed = limit;
    else if (reported == '0)    fixed = MIN_CODE;
    else                        fixed = reported;
  end
endmodule

// File: rtl/lnk_cap_gen.sv
module lnk_cap_gen
  import lnk_sync_pkg::*;
(
  input  logic [WID_W-1:0] max_width,
  input  logic [SPD_W-1:0] max_speed,
  output lnk_cap_t         caps
);
  logic fast;
  logic above_5g;
  logic [NVEC-1:0] vec;

  assign fast     = (max_speed > SPD_2G5);
  assign above_5g = (max_speed > SPD_5G);

  for (genvar i = 0; i < NVEC; i++) begin : g_vec
    localparam logic [SPD_W-1:0] CODE = SPD_W'(i + 1);
    assign vec[i] = above_5g && ((CODE <= SPD_8G) || (CODE <= max_speed));
  end

  always_comb begin
    caps.bw_notify  = (max_width > WID_X1) || fast;
    caps.active_rpt = fast;
    caps.tgt_speed  = fast ? max_speed : '0;
    caps.speed_vec  = vec;
  end
endmodule

// File: rtl/lnk_sta_merge.sv
module lnk_sta_merge
  import lnk_sync_pkg::*;
(
  input  logic [STA_W-1:0] own_sta,
  input  logic [WID_W-1:0] width,
  input  logic [SPD_W-1:0] speed,
  input  logic             force_active,
  output logic [STA_W-1:0] merged
);
  localparam logic [STA_W-1:0] FIELD_MASK =
    ({{(STA_W-WID_W){1'b0}}, {WID_W{1'b1}}} << WID_LSB) |
    ({{(STA_W-SPD_W){1'b0}}, {SPD_W{1'b1}}} << SPD_LSB);

  always_comb begin
    merged = own_sta & ~FIELD_MASK;
    merged[WID_LSB +: WID_W] = width;
    merged[SPD_LSB +: SPD_W] = speed;
    if (force_active) merged[ACT_BIT] = 1'b1;
  end
endmodule

// File: rtl/lnk_status_sync.sv
module lnk_status_sync
  import lnk_sync_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [WID_W-1:0] cfg_max_width_i,
  input  logic [SPD_W-1:0] cfg_max_speed_i,
  input  logic             dev_present_i,
  input  logic             dev_has_cap_i,
  input  logic [STA_W-1:0] dev_lnk_sta_i,
  input  logic [STA_W-1:0] own_lnk_sta_i,
  output logic [STA_W-1:0] lnk_sta_o,
  output logic             cap_bw_notify_o,
  output logic             cap_active_rpt_o,
  output logic [SPD_W-1:0] tgt_speed_o,
  output logic [NVEC-1:0]  speed_vec_o
);
  logic             no_dev;
  logic [WID_W-1:0] width_fix;
  logic [SPD_W-1:0] speed_fix;
  lnk_cap_t         caps_c;
  logic [STA_W-1:0] sta_c;

  assign no_dev = !dev_present_i || !dev_has_cap_i;

  lnk_field_fix #(.W(WID_W), .MIN_CODE(WID_X1)) u_width_fix (
    .use_limit (no_dev),
    .reported  (dev_lnk_sta_i[WID_LSB +: WID_W]),
    .limit     (cfg_max_width_i),
    .fixed     (width_fix)
  );

  lnk_field_fix #(.W(SPD_W), .MIN_CODE(SPD_2G5)) u_speed_fix (
    .use_limit (no_dev),
    .reported  (dev_lnk_sta_i[SPD_LSB +: SPD_W]),
    .limit     (cfg_max_speed_i),
    .fixed     (speed_fix)
  );

  lnk_cap_gen u_cap_gen (
    .max_width (cfg_max_width_i),
    .max_speed (cfg_max_speed_i),
    .caps      (caps_c)
  );

  lnk_sta_merge u_merge (
    .own_sta      (own_lnk_sta_i),
    .width        (width_fix),
    .speed        (speed_fix),
    .force_active (caps_c.active_rpt),
    .merged       (sta_c)
  );

  if (REG_OUT) begin : g_reg
    lnk_cap_t         caps_q;
    logic [STA_W-1:0] sta_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        caps_q <= '0;
        sta_q  <= '0;
      end else if (sync_i) begin
        caps_q <= caps_c;
        sta_q  <= sta_c;
      end
    end

    assign lnk_sta_o        = sta_q;
    assign cap_bw_notify_o  = caps_q.bw_notify;
    assign cap_active_rpt_o = caps_q.active_rpt;
    assign tgt_speed_o      = caps_q.tgt_speed;
    assign speed_vec_o      = caps_q.speed_vec;

    AST_WIDTH_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && cfg_max_width_i != '0) |=>
        (lnk_sta_o[WID_LSB +: WID_W] <= $past(cfg_max_width_i))); // R2
    AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && cfg_max_width_i != '0) |=>
        (lnk_sta_o[WID_LSB +: WID_W] != '0)); // R3
    AST_SPEED_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && cfg_max_speed_i != '0) |=>
        (lnk_sta_o[SPD_LSB +: SPD_W] <= $past(cfg_max_speed_i) &&
         lnk_sta_o[SPD_LSB +: SPD_W] != '0)); // R4
    AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && cfg_max_speed_i <= SPD_2G5) |=>
        (lnk_sta_o[STA_W-1:WID_LSB+WID_W] ==
         $past(own_lnk_sta_i[STA_W-1:WID_LSB+WID_W]))); // R5
    AST_ACTIVE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && cfg_max_speed_i > SPD_2G5) |=>
        (cap_active_rpt_o && lnk_sta_o[ACT_BIT])); // R7
    AST_HOLD_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> ($stable(lnk_sta_o) && $stable(speed_vec_o) &&
                   $stable(tgt_speed_o))); // R9
  end else begin : g_comb
    assign lnk_sta_o        = sta_c;
    assign cap_bw_notify_o  = caps_c.bw_notify;
    assign cap_active_rpt_o = caps_c.active_rpt;
    assign tgt_speed_o      = caps_c.tgt_speed;
    assign speed_vec_o      = caps_c.speed_vec;
  end
endmodule

// File: tb/lnk_status_sync_tb_top.sv
module lnk_status_sync_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic [5:0]  max_w = 6'd8;
  logic [3:0]  max_s = 4'd3;
  logic        present = 1'b0;
  logic        has_cap = 1'b0;
  logic [15:0] dev_sta = '0;
  logic [15:0] own_sta = '0;
  logic [15:0] sta_o;
  logic        bw_o, act_o;
  logic [3:0]  tgt_o, vec_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lnk_status_sync dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .cfg_max_width_i(max_w), .cfg_max_speed_i(max_s),
    .dev_present_i(present), .dev_has_cap_i(has_cap),
    .dev_lnk_sta_i(dev_sta), .own_lnk_sta_i(own_sta),
    .lnk_sta_o(sta_o), .cap_bw_notify_o(bw_o), .cap_active_rpt_o(act_o),
    .tgt_speed_o(tgt_o), .speed_vec_o(vec_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_sync();
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset sta", 32'(sta_o), 32'h0);
    check("R9 reset caps", {bw_o, act_o, tgt_o, vec_o}, 32'h0);
  endtask

  task automatic t_no_device();
    max_w = 6'd8; max_s = 4'd3; present = 1'b0; has_cap = 1'b1;
    dev_sta = 16'h0025; own_sta = 16'h0000;
    do_sync();
    check("R1 no device width", 32'(sta_o[9:4]), 32'd8);
    check("R1 no device speed", 32'(sta_o[3:0]), 32'd3);
    check("R7 active bit forced", 32'(sta_o), 32'h2083);
    present = 1'b1; has_cap = 1'b0;
    do_sync();
    check("R1 no capability word", 32'(sta_o), 32'h2083);
  endtask

  task automatic t_clamp();
    present = 1'b1; has_cap = 1'b1; max_w = 6'd8; max_s = 4'd3; own_sta = 16'h0;
    dev_sta = (16'd16 << 4) | 16'd2;
    do_sync();
    check("R2 width clamped", 32'(sta_o[9:4]), 32'd8);
    check("R4 speed in range", 32'(sta_o[3:0]), 32'd2);
    dev_sta = (16'd2 << 4) | 16'd5;
    do_sync();
    check("R4 speed clamped", 32'(sta_o[3:0]), 32'd3);
    check("R2 width in range", 32'(sta_o[9:4]), 32'd2);
  endtask

  task automatic t_zero_fix();
    dev_sta = 16'h0000;
    do_sync();
    check("R3 zero width to x1", 32'(sta_o[9:4]), 32'd1);
    check("R4 zero speed to 2.5", 32'(sta_o[3:0]), 32'd1);
    dev_sta = (16'd8 << 4) | 16'd3;
    do_sync();
    check("R2 width at max", 32'(sta_o[9:4]), 32'd8);
    check("R4 speed at max", 32'(sta_o[3:0]), 32'd3);
  endtask

  task automatic t_preserve();
    max_w = 6'd1; max_s = 4'd1; dev_sta = 16'h0011;
    own_sta = 16'hDC00;
    do_sync();
    check("R5 upper kept bit13 clear", 32'(sta_o), 32'hDC11);
    own_sta = 16'hFFFF;
    do_sync();
    check("R5 low fields overwritten", 32'(sta_o), 32'hFC11);
    check("R6 bw off at x1 2.5", 32'(bw_o), 32'd0);
    check("R7 slow caps", {act_o, tgt_o}, 32'h0);
    check("R8 vec slow", 32'(vec_o), 32'h0);
    max_s = 4'd2; own_sta = 16'h0400;
    do_sync();
    check("R5 bit13 forced at 5G", 32'(sta_o[15:10]), 32'h09);
  endtask

  task automatic t_caps();
    max_w = 6'd4; max_s = 4'd1;
    do_sync();
    check("R6 bw from width", 32'(bw_o), 32'd1);
    check("R7 no active at 2.5", {act_o, tgt_o}, 32'h0);
    max_w = 6'd1; max_s = 4'd2;
    do_sync();
    check("R6 bw from speed", 32'(bw_o), 32'd1);
    check("R7 caps at 5G", {act_o, tgt_o}, 32'h12);
    check("R8 vec at 5G", 32'(vec_o), 32'h0);
    max_s = 4'd3;
    do_sync();
    check("R8 vec at 8G", 32'(vec_o), 32'h7);
    check("R7 tgt at 8G", 32'(tgt_o), 32'd3);
    max_s = 4'd4;
    do_sync();
    check("R8 vec at 16G", 32'(vec_o), 32'hF);
    check("R7 tgt at 16G", 32'(tgt_o), 32'd4);
  endtask

  task automatic t_hold();
    logic [15:0] prev_sta;
    logic [3:0]  prev_vec;
    prev_sta = sta_o; prev_vec = vec_o;
    max_s = 4'd1; max_w = 6'd2; own_sta = 16'h5555; dev_sta = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9 sta held without sync", 32'(sta_o), 32'(prev_sta));
    check("R9 vec held without sync", 32'(vec_o), 32'(prev_vec));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_device();
    t_clamp();
    t_zero_fix();
    t_preserve();
    t_caps();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule